// File: doc/BRIEF.md
# Registered Logarithmic Right Shifter

This block shifts a data word to the right by a variable number of positions and registers the outcome, so one shift is accepted and finished on every clock. The distance comes in as a full-width unsigned amount. A mode input picks one of two fills for the vacated top positions. The arithmetic fill repeats the sign (the most significant input bit). The logical fill inserts zeros.

The shift is built from a chain of binary 2:1 multiplexer stages, one per bit of the low part of the amount. Stage j moves the word by 2^j places when amount bit j is set. Any amount of DATA_W or more does not fit in those low bits. The upper amount bits are OR-reduced to detect this case, and the stage output is then replaced by a word made only of fill bits. The data width is a power-of-two parameter, and the stage count is derived from it.

Top module: `rshift_unit`

## Requirements
- R1: With `arith` = 1 (arithmetic mode), every vacated top position of the result holds a copy of the input's most significant bit.
- R2: With `arith` = 0 (logical mode), every vacated top position of the result is 0.
- R3: An amount of zero returns the input word unchanged in both modes.
- R4: Any amount of DATA_W or greater gives a word made only of fill bits (all copies of the input MSB when `arith` = 1, all zeros when `arith` = 0). This includes amounts whose only set bits lie above the low log2(DATA_W) bits.
- R5: For an amount k below DATA_W, result bit i equals input bit i+k when i+k < DATA_W, and equals the fill bit otherwise.
- R6: Inputs are sampled on a rising clock edge, and their result appears on `result` after that edge. A new, independent shift can be issued on every cycle.
- R7: Reset is synchronous and active low. A rising edge with `rst_n` = 0 clears `result` to all zeros. Lowering `rst_n` between edges leaves `result` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | DATA_W | Word to be shifted |
| shamt | input | AMT_W | Unsigned shift distance |
| arith | input | 1 | 1 = sign fill, 0 = zero fill |
| result | output | DATA_W | Registered shifted word |

## Verification
The saturation path is the hardest case to reach on purpose. A plain sweep of small amounts only ever drives the low amount bits. The override fires only when one of the many upper amount bits is set. It must also be told apart from a large in-range shift, which gives almost the same word. To cover this, the bench drives amounts equal to DATA_W and just past it, a single isolated top bit, and all ones. It pairs each of these with an amount of DATA_W-1, using negative and positive data in both modes, so that a missing override or a wrong fill shows up in exactly one bit.

// File: rtl/rshift_pkg.sv
// Package: shared types for the right-shifter.
// Assumes: nothing beyond IEEE 1800-2017.
package rshift_pkg;

    // Fill mode; the encoding matches the top-level arith pin.
    typedef enum logic {
        SHR_LOGICAL = 1'b0,
        SHR_ARITH   = 1'b1
    } shr_mode_e;

    // Fill bit for the vacated positions, taken from the unshifted MSB.
    function automatic logic fill_of(input logic msb, input shr_mode_e mode);
        return (mode == SHR_ARITH) ? msb : 1'b0;
    endfunction

endpackage

// File: rtl/shr_range_detect.sv
// Module: shr_range_detect
// Flags shift amounts that do not fit in the STAGES low bits, i.e. amount >= 2**STAGES.
// Assumes: AMT_W >= STAGES; when they are equal there is no overflow.
module shr_range_detect #(
    parameter int AMT_W  = 32,
    parameter int STAGES = 5
) (
    input  logic [AMT_W-1:0] amt,
    output logic             over
);
    generate
        if (AMT_W > STAGES) begin : g_wide
            // OR-reduce every amount bit above the stage-control bits.
            assign over = |amt[AMT_W-1:STAGES];
        end else begin : g_narrow
            // The full amount drives the stages, so it can never overflow.
            assign over = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/shr_mux_stage.sv
// Module: shr_mux_stage
// One 2:1 stage: passes the word, or shifts it right by DIST and inserts fill bits.
// Assumes: 0 < DIST < W.
module shr_mux_stage #(
    parameter int W    = 32,
    parameter int DIST = 1
) (
    input  logic [W-1:0] din,
    input  logic         sel,
    input  logic         fill,
    output logic [W-1:0] dout
);
    // Select between the pass-through word and the shifted word.
    always_comb begin
        if (sel) dout = {{DIST{fill}}, din[W-1:DIST]};
        else     dout = din;
    end
endmodule

// File: rtl/shr_barrel.sv
// Module: shr_barrel
// Chain of log2(W) mux stages; stage j shifts by 2**j under control of amt bit j.
// Assumes: W == 2**STAGES.
module shr_barrel #(
    parameter int W      = 32,
    parameter int STAGES = 5
) (
    input  logic [W-1:0]      din,
    input  logic [STAGES-1:0] amt,
    input  logic              fill,
    output logic [W-1:0]      dout
);
    logic [W-1:0] tap [STAGES+1];

    assign tap[0] = din;

    generate
        for (genvar j = 0; j < STAGES; j++) begin : g_stage
            shr_mux_stage #(
                .W    (W),
                .DIST (1 << j)
            ) u_stage (
                .din  (tap[j]),
                .sel  (amt[j]),
                .fill (fill),
                .dout (tap[j+1])
            );
        end
    endgenerate

    assign dout = tap[STAGES];
endmodule

// File: rtl/rshift_unit.sv
// Module: rshift_unit
// Single-cycle registered right shifter with sign or zero fill and saturation.
// Assumes: DATA_W is a power of two >= 2; AMT_W >= log2(DATA_W);
//          reset is synchronous and active low.
module rshift_unit
    import rshift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic [AMT_W-1:0]  shamt,
    input  logic              arith,
    output logic [DATA_W-1:0] result
);
    localparam int STAGES = $clog2(DATA_W);
    localparam int MSB    = DATA_W - 1;

    generate
        if ((1 << STAGES) != DATA_W || STAGES < 1) begin : g_bad_width
            $error("rshift_unit: DATA_W must be a power of two >= 2");
        end
    endgenerate

    shr_mode_e         mode;
    logic              fill;
    logic              over;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] next_q;

    assign mode = shr_mode_e'(arith);
    assign fill = fill_of(data_in[MSB], mode);

    shr_range_detect #(
        .AMT_W  (AMT_W),
        .STAGES (STAGES)
    ) u_range (
        .amt  (shamt),
        .over (over)
    );

    shr_barrel #(
        .W      (DATA_W),
        .STAGES (STAGES)
    ) u_barrel (
        .din  (data_in),
        .amt  (shamt[STAGES-1:0]),
        .fill (fill),
        .dout (shifted)
    );

    // Choose the saturated fill word when the amount is out of range.
    always_comb begin
        next_q = over ? {DATA_W{fill}} : shifted;
    end

    // Result register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) result <= '0;
        else        result <= next_q;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (result == '0)); // R7

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (shamt == '0) |=> (result == $past(data_in))); // R3

    AST_SAT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (shamt >= AMT_W'(DATA_W)) |=>
            (result == {DATA_W{$past(arith) & $past(data_in[MSB])}})); // R4

    AST_LOGICAL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!arith && shamt != '0) |=> (result[MSB] == 1'b0)); // R2

    AST_ARITH_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        arith |=> (result[MSB] == $past(data_in[MSB]))); // R1
endmodule

// File: tb/tb_rshift_unit.sv
`timescale 1ns/1ps
module tb_rshift_unit;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] data_in = '0;
    logic [31:0]  shamt = '0;
    logic         arith = 1'b0;
    logic [W-1:0] result;

    int n_cmp = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rshift_unit #(.DATA_W(W), .AMT_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in),
        .shamt(shamt), .arith(arith), .result(result)
    );

    // Expected value written directly from the bit rule in R5 and R4.
    function automatic logic [W-1:0] model(input logic [W-1:0] d, input logic [31:0] k,
                                           input logic ar);
        logic [W-1:0] r;
        logic f;
        f = ar & d[W-1];
        for (int i = 0; i < W; i++) begin
            if (k < 32'(W) && (i + int'(k)) < W) r[i] = d[i + int'(k)];
            else                                 r[i] = f;
        end
        return r;
    endfunction

    task automatic check(input logic [W-1:0] exp, input string req);
        n_cmp++;
        if (result !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, result, exp);
        end
    endtask

    // Issue one shift at a falling edge and compare just after the capturing edge.
    task automatic shift_one(input logic [W-1:0] d, input logic [31:0] k,
                             input logic ar, input string req);
        @(negedge clk);
        data_in = d; shamt = k; arith = ar;
        @(posedge clk);
        #1;
        check(model(d, k, ar), req);
    endtask

    task automatic t_reset_state;
        rst_n = 1'b0;
        data_in = 32'hFFFF_FFFF; shamt = 32'd0; arith = 1'b1;
        repeat (2) @(posedge clk);
        #1 check('0, "R7 reset state");
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_arith;
        shift_one(32'h8000_0000, 32'd1,  1'b1, "R1 arith k=1");
        shift_one(32'hF00F_1234, 32'd4,  1'b1, "R1 arith k=4");
        shift_one(32'h9ABC_DEF0, 32'd31, 1'b1, "R1 arith k=31");
        shift_one(32'h7FFF_FFFF, 32'd8,  1'b1, "R1 arith positive");
    endtask

    task automatic t_logical;
        shift_one(32'h8000_0000, 32'd1,  1'b0, "R2 logical k=1");
        shift_one(32'hFFFF_FFFF, 32'd16, 1'b0, "R2 logical k=16");
        shift_one(32'hDEAD_BEEF, 32'd31, 1'b0, "R2 logical k=31");
    endtask

    task automatic t_zero_amount;
        shift_one(32'hDEAD_BEEF, 32'd0, 1'b1, "R3 zero arith");
        shift_one(32'h8765_4321, 32'd0, 1'b0, "R3 zero logical");
    endtask

    task automatic t_saturate;
        logic [31:0] amts [5] = '{32'd32, 32'd33, 32'h0000_0100, 32'h8000_0000, 32'hFFFF_FFFF};
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 5; a++) begin
                shift_one(32'hC000_0001, amts[a], m[0], "R4 saturate neg");
                shift_one(32'h4000_0001, amts[a], m[0], "R4 saturate pos");
            end
            shift_one(32'hC000_0001, 32'd31, m[0], "R4 boundary k=31");
        end
    endtask

    task automatic t_sweep;
        logic [W-1:0] pats [4] = '{32'hA5A5_5A5A, 32'h8000_0001, 32'h1357_9BDF, 32'hFEDC_BA98};
        for (int p = 0; p < 4; p++)
            for (int m = 0; m < 2; m++)
                for (int k = 0; k < 34; k++)
                    shift_one(pats[p], 32'(k), m[0], "R5 bit mapping");
    endtask

    task automatic t_stream;
        logic [W-1:0] exp_prev;
        exp_prev = '0;
        for (int n = 0; n < 12; n++) begin
            @(negedge clk);
            if (n > 0) check(exp_prev, "R6 back-to-back");
            data_in = 32'h8123_4567 ^ (32'(n) * 32'h0101_0101);
            shamt   = 32'(n * 3);
            arith   = n[0];
            exp_prev = model(data_in, shamt, arith);
        end
        @(negedge clk);
        check(exp_prev, "R6 back-to-back last");
    endtask

    task automatic t_sync_reset;
        logic [W-1:0] held;
        shift_one(32'hF000_0000, 32'd2, 1'b1, "R7 preload");
        held = result;
        @(negedge clk);
        rst_n = 1'b0;
        #1 check(held, "R7 held before edge");
        @(posedge clk);
        #1 check('0, "R7 cleared at edge");
        @(negedge clk) rst_n = 1'b1;
    endtask

    initial begin
        t_reset_state();
        t_arith();
        t_logical();
        t_zero_amount();
        t_saturate();
        t_sweep();
        t_stream();
        t_sync_reset();
        shift_one(32'h8000_0000, 32'd3, 1'b1, "R6 after reset");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_cmp++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end
endmodule